// File: doc/BRIEF.md
# Decision Handshake Recorder

This block sits between a decision processor and a trigger supervisor. The processor returns its verdict for an event as a short framed message on a word-wide link. The block keeps the whole message in a small buffer and takes the accept/reject bit from the first word. It then runs a four-phase request/acknowledge exchange with the supervisor to pass that bit on. Finally it watches the broadcast lines for the global verdict on the event.

A free-running cycle counter restarts at every level-1 accept. Four milestones are stamped against it: message returned, handshake started, handshake finished and broadcast verdict seen. The stamps for the event in progress and for the event before it are kept side by side, behind a small select port. A one-entry queue holds a verdict that arrives while the supervisor exchange is still busy. Sticky flags report supervisor timeouts and verdicts lost to a full queue.

Top module: `dec_handshake_rec`

## Requirements
- R1: While reset is asserted, and right after it, `sup_req`, both error flags, `msg_len`, `bcast_acc_q`, every buffer word and all eight stamps read zero. The cycle counter also starts at zero.
- R2: Each word accepted on the link is written to buffer slot 0, 1, 2 and so on within its frame. Words beyond `DEPTH` are dropped. On the edge that takes the last word (`lnk_last`), `msg_len` becomes the frame's word count, capped at `DEPTH`.
- R3: The verdict sent to the supervisor (`sup_dec`, 1 = accept) is bit 0 of the first word of the frame.
- R4: On the clock edge after a verdict waits in the queue with the exchange idle, `sup_req` rises with `sup_dec`. Both hold until `sup_ack` is sampled high, and then `sup_req` falls. No new request starts until `sup_ack` is sampled low.
- R5: If the exchange waits `TMO_CYC` cycles in the request phase or the release phase without progress, the exchange returns to idle with `sup_req` low, and `err_tmo` sets and stays set until reset.
- R6: A completed frame first enters a one-entry queue. If the exchange is idle, the queued verdict is taken on the next edge. A frame that completes on the edge where the entry is taken refills the queue. Verdicts are sent in arrival order.
- R7: A frame that completes while the queue is full and not being drained in that cycle is dropped. `err_ovf` then sets and stays set until reset.
- R8: The cycle counter goes to zero on the edge that samples `l1a`. It then rises by one per cycle and holds at its all-ones value.
- R9: Each milestone stamps the counter value current at its edge into its current-event slot. The return stamp is taken on the edge of the last link word, the start stamp on the edge where `sup_req` rises, the end stamp on the edge where a low `sup_ack` ends the release phase, and the broadcast stamp on the edge of `bcast_valid`. `tsel[1:0]` selects 0 return, 1 start, 2 end, 3 broadcast. `tsel[2]`=1 selects the previous-event set.
- R10: On an `l1a` edge the current set is copied to the previous set and the current set is cleared. A milestone on that same edge is not recorded.
- R11: `bcast_acc_q` holds the `bcast_acc` value from the most recent `bcast_valid` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1a | input | 1 | Level-1 accept strobe, starts a new event |
| lnk_valid | input | 1 | Link word valid |
| lnk_data | input | WORD_W | Link word |
| lnk_last | input | 1 | Marks the final word of a frame |
| sup_ack | input | 1 | Supervisor acknowledge |
| sup_req | output | 1 | Request to supervisor |
| sup_dec | output | 1 | Verdict offered with the request (1 = accept) |
| bcast_valid | input | 1 | Broadcast verdict strobe |
| bcast_acc | input | 1 | Broadcast verdict value |
| bcast_acc_q | output | 1 | Last broadcast verdict seen |
| buf_addr | input | clog2(DEPTH) | Buffer read slot |
| buf_data | output | WORD_W | Buffer word at `buf_addr` |
| msg_len | output | clog2(DEPTH+1) | Word count of the last completed frame |
| tsel | input | 3 | Stamp select |
| tdata | output | CNT_W | Selected stamp |
| err_tmo | output | 1 | Sticky supervisor timeout |
| err_ovf | output | 1 | Sticky queue overflow |

## Verification
A bad exchange state shows on `sup_req` within one cycle of the `sup_ack` change that should have moved it. A lost or doubled queue entry shows as a missing or extra request, or as a wrong `sup_dec`, a few cycles after the frame ends. A wrong counter value or a wrong roll-over appears in the stamp slots at the next milestone. It appears in the previous set at the next level-1 accept. The bench compares every output and every stamp slot with its own model on every cycle, so the first cycle in error is reported.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_REL  = 2'd2
  } hs_state_t;

  localparam int NUM_MS   = 4;
  localparam int MS_RET   = 0;
  localparam int MS_START = 1;
  localparam int MS_END   = 2;
  localparam int MS_GLOB  = 3;
endpackage

// File: rtl/dhr_frame_rx.sv
module dhr_frame_rx #(
  parameter  int WORD_W = 16,
  parameter  int DEPTH  = 4,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [LW-1:0]     msg_len,
  output logic              done,
  output logic              done_acc
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [LW-1:0]     wcnt_q, wcnt_d, wcnt_inc, len_q, len_d;
  logic              acc_q, acc_d, wr_en;

  always_comb begin
    wcnt_inc = (wcnt_q == LW'(DEPTH)) ? wcnt_q : wcnt_q + 1'b1;
    wr_en    = in_valid && (wcnt_q < LW'(DEPTH));
    wcnt_d   = wcnt_q;
    len_d    = len_q;
    acc_d    = acc_q;
    if (in_valid) begin
      if (wcnt_q == '0) acc_d = in_data[0];
      if (in_last) begin
        wcnt_d = '0;
        len_d  = wcnt_inc;
      end else begin
        wcnt_d = wcnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      len_q  <= '0;
      acc_q  <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      len_q  <= len_d;
      acc_q  <= acc_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      mem_q[i] <= '0;
      else if (wr_en && (wcnt_q[AW-1:0] == AW'(i)))    mem_q[i] <= in_data;
    end
  end

  assign rd_data  = (32'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;
  assign msg_len  = len_q;
  assign done     = in_valid & in_last;
  assign done_acc = (wcnt_q == '0) ? in_data[0] : acc_q;

  // R2
  len_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (len_q != '0));
endmodule

// File: rtl/dhr_hs_fsm.sv
module dhr_hs_fsm
  import dhr_pkg::*;
#(
  parameter  int TMO_CYC = 16,
  localparam int TW      = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic done_acc,
  input  logic ack,
  output logic req,
  output logic dec,
  output logic start_pulse,
  output logic end_pulse,
  output logic err_tmo,
  output logic err_ovf
);
  hs_state_t     st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          dec_q, dec_d, pv_q, pv_d, pacc_q, pacc_d;
  logic          tmo_q, tmo_d, ovf_q, ovf_d, take, tmo_hit;

  always_comb begin
    take        = (st_q == HS_IDLE) && pv_q;
    tmo_hit     = (tcnt_q == TW'(TMO_CYC - 1));
    st_d        = st_q;
    tcnt_d      = tcnt_q;
    dec_d       = dec_q;
    tmo_d       = tmo_q;
    start_pulse = 1'b0;
    end_pulse   = 1'b0;
    unique case (st_q)
      HS_IDLE: if (take) begin
        st_d        = HS_REQ;
        dec_d       = pacc_q;
        tcnt_d      = '0;
        start_pulse = 1'b1;
      end
      HS_REQ: if (ack) begin
        st_d   = HS_REL;
        tcnt_d = '0;
      end else if (tmo_hit) begin
        st_d  = HS_IDLE;
        tmo_d = 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
      HS_REL: if (!ack) begin
        st_d      = HS_IDLE;
        end_pulse = 1'b1;
      end else if (tmo_hit) begin
        st_d  = HS_IDLE;
        tmo_d = 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
      default: st_d = HS_IDLE;
    endcase
    ovf_d  = ovf_q | (done & pv_q & ~take);
    pacc_d = (done && (!pv_q || take)) ? done_acc : pacc_q;
    pv_d   = done ? 1'b1 : (take ? 1'b0 : pv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      tcnt_q <= '0;
      dec_q  <= 1'b0;
      pv_q   <= 1'b0;
      pacc_q <= 1'b0;
      tmo_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      dec_q  <= dec_d;
      pv_q   <= pv_d;
      pacc_q <= pacc_d;
      tmo_q  <= tmo_d;
      ovf_q  <= ovf_d;
    end
  end

  assign req     = (st_q == HS_REQ);
  assign dec     = dec_q;
  assign err_tmo = tmo_q;
  assign err_ovf = ovf_q;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !tmo_hit) |=> (req && $stable(dec)));
  // R4
  rel_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_REL) |=> !req);
  // R5
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |=> err_tmo);
  // R6
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(pv_q));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);
endmodule

// File: rtl/dhr_stamp_regs.sv
module dhr_stamp_regs
  import dhr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1a,
  input  logic [NUM_MS-1:0] ms_hit,
  input  logic [2:0]        sel,
  output logic [CNT_W-1:0]  rd_stamp
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cur_q [NUM_MS];
  logic [CNT_W-1:0] prv_q [NUM_MS];

  always_comb begin
    if (l1a)                  cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NUM_MS; i++) begin : g_ms
    logic [CNT_W-1:0] cur_d, prv_d;
    always_comb begin
      cur_d = cur_q[i];
      prv_d = prv_q[i];
      if (l1a) begin
        prv_d = cur_q[i];
        cur_d = '0;
      end else if (ms_hit[i]) begin
        cur_d = cnt_q;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[i] <= '0;
        prv_q[i] <= '0;
      end else begin
        cur_q[i] <= cur_d;
        prv_q[i] <= prv_d;
      end
    end
    // R10
    roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l1a |=> ((prv_q[i] == $past(cur_q[i])) && (cur_q[i] == '0)));
  end

  assign rd_stamp = sel[2] ? prv_q[sel[1:0]] : cur_q[sel[1:0]];

  // R8
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1a |=> (cnt_q == '0));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l1a && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/dec_handshake_rec.sv
module dec_handshake_rec
  import dhr_pkg::*;
#(
  parameter  int WORD_W  = 16,
  parameter  int DEPTH   = 4,
  parameter  int CNT_W   = 16,
  parameter  int TMO_CYC = 16,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1a,
  input  logic              lnk_valid,
  input  logic [WORD_W-1:0] lnk_data,
  input  logic              lnk_last,
  input  logic              sup_ack,
  output logic              sup_req,
  output logic              sup_dec,
  input  logic              bcast_valid,
  input  logic              bcast_acc,
  output logic              bcast_acc_q,
  input  logic [AW-1:0]     buf_addr,
  output logic [WORD_W-1:0] buf_data,
  output logic [LW-1:0]     msg_len,
  input  logic [2:0]        tsel,
  output logic [CNT_W-1:0]  tdata,
  output logic              err_tmo,
  output logic              err_ovf
);
  logic              done, done_acc, start_pulse, end_pulse, gacc_d;
  logic [NUM_MS-1:0] hits;

  dhr_frame_rx #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(lnk_valid), .in_data(lnk_data),
    .in_last(lnk_last), .rd_addr(buf_addr), .rd_data(buf_data),
    .msg_len(msg_len), .done(done), .done_acc(done_acc)
  );

  dhr_hs_fsm #(.TMO_CYC(TMO_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .done(done), .done_acc(done_acc),
    .ack(sup_ack), .req(sup_req), .dec(sup_dec),
    .start_pulse(start_pulse), .end_pulse(end_pulse),
    .err_tmo(err_tmo), .err_ovf(err_ovf)
  );

  always_comb begin
    hits           = '0;
    hits[MS_RET]   = done;
    hits[MS_START] = start_pulse;
    hits[MS_END]   = end_pulse;
    hits[MS_GLOB]  = bcast_valid;
    gacc_d         = bcast_valid ? bcast_acc : bcast_acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcast_acc_q <= 1'b0;
    else        bcast_acc_q <= gacc_d;
  end

  dhr_stamp_regs #(.CNT_W(CNT_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .l1a(l1a), .ms_hit(hits),
    .sel(tsel), .rd_stamp(tdata)
  );

  // R11
  bcast_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |=> (bcast_acc_q == $past(bcast_acc)));
endmodule

// File: tb/tb_dec_handshake_rec.sv
`timescale 1ns/100ps
module tb_dec_handshake_rec;
  localparam int W   = 16;
  localparam int D   = 4;
  localparam int CW  = 6;
  localparam int TMO = 16;
  localparam int AW  = 2;
  localparam int LW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic l1a, lnk_valid, lnk_last, sup_ack, bcast_valid, bcast_acc;
  logic [W-1:0]  lnk_data;
  logic [AW-1:0] buf_addr;
  logic [2:0]    tsel;
  logic sup_req, sup_dec, bcast_acc_q, err_tmo, err_ovf;
  logic [W-1:0]  buf_data;
  logic [LW-1:0] msg_len;
  logic [CW-1:0] tdata;

  always #2.5 clk = ~clk;

  dec_handshake_rec #(.WORD_W(W), .DEPTH(D), .CNT_W(CW), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .l1a(l1a), .lnk_valid(lnk_valid),
    .lnk_data(lnk_data), .lnk_last(lnk_last), .sup_ack(sup_ack),
    .sup_req(sup_req), .sup_dec(sup_dec), .bcast_valid(bcast_valid),
    .bcast_acc(bcast_acc), .bcast_acc_q(bcast_acc_q), .buf_addr(buf_addr),
    .buf_data(buf_data), .msg_len(msg_len), .tsel(tsel), .tdata(tdata),
    .err_tmo(err_tmo), .err_ovf(err_ovf)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  logic [W-1:0]  m_buf [D];
  int            m_wcnt, m_len, m_st, m_tcnt;
  bit            m_acc, m_pv, m_pacc, m_dec, m_tmo, m_ovf, m_gacc;
  int            m_cnt;
  int            m_cur [4];
  int            m_prv [4];
  bit            t_done, t_dacc, t_take, t_start, t_end;

  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) m_buf[i] = '0;
      for (int i = 0; i < 4; i++) begin m_cur[i] = 0; m_prv[i] = 0; end
      m_wcnt = 0; m_len = 0; m_st = 0; m_tcnt = 0; m_acc = 0; m_pv = 0;
      m_pacc = 0; m_dec = 0; m_tmo = 0; m_ovf = 0; m_gacc = 0; m_cnt = 0;
    end else begin
      t_done  = lnk_valid && lnk_last;
      t_dacc  = (m_wcnt == 0) ? lnk_data[0] : m_acc;
      t_take  = (m_st == 0) && m_pv;
      t_start = 0; t_end = 0;
      // R2 R3 frame capture
      if (lnk_valid) begin
        if (m_wcnt < D) m_buf[m_wcnt] = lnk_data;
        if (m_wcnt == 0) m_acc = lnk_data[0];
        if (lnk_last) begin m_len = sat_inc(m_wcnt, D); m_wcnt = 0; end
        else m_wcnt = sat_inc(m_wcnt, D);
      end
      // R4 R5 exchange
      case (m_st)
        0: if (t_take) begin m_st = 1; m_dec = m_pacc; m_tcnt = 0; t_start = 1; end
        1: if (sup_ack) begin m_st = 2; m_tcnt = 0; end
           else if (m_tcnt == TMO - 1) begin m_st = 0; m_tmo = 1; end
           else m_tcnt++;
        default: if (!sup_ack) begin m_st = 0; t_end = 1; end
           else if (m_tcnt == TMO - 1) begin m_st = 0; m_tmo = 1; end
           else m_tcnt++;
      endcase
      // R6 R7 queue
      if (t_done && m_pv && !t_take) m_ovf = 1;
      if (t_done) begin
        if (!m_pv || t_take) m_pacc = t_dacc;
        m_pv = 1;
      end else if (t_take) m_pv = 0;
      // R8 R9 R10 stamps
      if (l1a) begin
        for (int i = 0; i < 4; i++) begin m_prv[i] = m_cur[i]; m_cur[i] = 0; end
      end else begin
        if (t_done)      m_cur[0] = m_cnt;
        if (t_start)     m_cur[1] = m_cnt;
        if (t_end)       m_cur[2] = m_cnt;
        if (bcast_valid) m_cur[3] = m_cnt;
      end
      m_cnt = l1a ? 0 : sat_inc(m_cnt, (1 << CW) - 1);
      // R11
      if (bcast_valid) m_gacc = bcast_acc;
    end
  end

  // output comparison every cycle, away from the active edge
  initial begin
    buf_addr = '0;
    tsel = '0;
    forever begin
      @(negedge clk);
      #0.5;
      if (!rst_n) begin
        chk(sup_req == 1'b0, "R1 sup_req in reset", sup_req, 0);
        chk(err_tmo == 1'b0 && err_ovf == 1'b0, "R1 error flags in reset", {err_tmo, err_ovf}, 0);
        chk(msg_len == '0, "R1 msg_len in reset", msg_len, 0);
      end
      chk(sup_req == (m_st == 1), "R4 sup_req", sup_req, (m_st == 1));
      chk(sup_dec == m_dec, "R3 R6 sup_dec", sup_dec, m_dec);
      chk(err_tmo == m_tmo, "R5 err_tmo", err_tmo, m_tmo);
      chk(err_ovf == m_ovf, "R7 err_ovf", err_ovf, m_ovf);
      chk(int'(msg_len) == m_len, "R2 msg_len", msg_len, m_len);
      chk(bcast_acc_q == m_gacc, "R11 bcast_acc_q", bcast_acc_q, m_gacc);
      for (int i = 0; i < D; i++) begin
        buf_addr = AW'(i);
        #0.1;
        chk(buf_data == m_buf[i], "R2 buffer word", buf_data, m_buf[i]);
      end
      for (int i = 0; i < 8; i++) begin
        int e;
        tsel = 3'(i);
        #0.1;
        e = (i >= 4) ? m_prv[i-4] : m_cur[i];
        // R8 counter values show through the stamps
        if (i >= 4) chk(int'(tdata) == e, "R10 previous stamp", tdata, e);
        else        chk(int'(tdata) == e, "R9 R8 current stamp", tdata, e);
      end
    end
  end

  // stimulus
  int words_left = 0;
  int ack_dly = 0;
  bit stuck;

  task automatic drive_cycle(input int cyc);
    stuck = ((cyc / 300) % 4) == 3;
    l1a         = ($urandom % 60) == 0;
    bcast_valid = ($urandom % 25) == 0;
    bcast_acc   = 1'($urandom);
    lnk_valid = 1'b0; lnk_last = 1'b0; lnk_data = W'($urandom);
    if (words_left == 0 && ($urandom % 12) == 0) words_left = 1 + ($urandom % 6);
    if (words_left > 0 && ($urandom % 4) != 0) begin
      lnk_valid = 1'b1;
      words_left--;
      lnk_last = (words_left == 0);
    end
    if (sup_req && !sup_ack) begin
      if (!stuck) begin
        if (ack_dly == 0) begin sup_ack = 1'b1; ack_dly = $urandom % 5; end
        else ack_dly--;
      end
    end else if (!sup_req && sup_ack) begin
      if (ack_dly == 0) begin sup_ack = 1'b0; ack_dly = $urandom % 6; end
      else ack_dly--;
    end
  endtask

  task automatic idle_inputs();
    l1a = 0; lnk_valid = 0; lnk_last = 0; lnk_data = '0;
    sup_ack = 0; bcast_valid = 0; bcast_acc = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // directed: single frame, decision reject then accept, R3 R9
    @(negedge clk) begin l1a = 1; end
    @(negedge clk) begin l1a = 0; lnk_valid = 1; lnk_data = 16'h00A2; lnk_last = 0; end
    @(negedge clk) begin lnk_data = 16'h1234; lnk_last = 1; end
    @(negedge clk) begin lnk_valid = 0; lnk_last = 0; end
    @(negedge clk) begin sup_ack = 1; end
    @(negedge clk) begin sup_ack = 0; end
    @(negedge clk) begin bcast_valid = 1; bcast_acc = 1; end
    @(negedge clk) begin
      bcast_valid = 0;
      // R10: milestone on the same edge as l1a is dropped
      l1a = 1; lnk_valid = 1; lnk_last = 1; lnk_data = 16'h0001;
    end
    @(negedge clk) begin l1a = 0; lnk_valid = 0; lnk_last = 0; end
    repeat (4) @(negedge clk);
    // directed overflow: three frames with supervisor silent, R5 R7
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) begin lnk_valid = 1; lnk_last = 1; lnk_data = W'(k); end
    end
    @(negedge clk) begin lnk_valid = 0; lnk_last = 0; end
    repeat (40) @(negedge clk);
    // mid-run reset, R1
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      drive_cycle(c);
      if (c == 3000) begin
        rst_n = 1'b0;
        idle_inputs();
        words_left = 0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
      end
    end
    @(negedge clk) idle_inputs();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL R4 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule